// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers per-bit event pulses from a hardware monitoring scan loop and publishes them through two 8-bit interrupt status registers. Events are first held in a hidden accumulator and only become visible when the scan loop signals the end of a pass. Software reads a status register through a simple register port, and the read also empties it. The register stays at zero until the next end-of-pass strobe refills it.

Two mask registers, one per status register, decide which status bits may drive the single interrupt pin. A mask bit of 0 lets its status bit through. An active-low interrupt from other devices is chained onto the same pin. A configuration register holds the pin enable and the pin polarity. It also holds a line-clear control, which silences the pin without touching status and holds the scan loop halted while it is set.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status, mask and configuration registers read 0, `irq_pin` is 1 (inactive, active-low) and `scan_halt` is 0.
- R2: An event pulse on `evt[i]` does not change any status register until the next `scan_done` strobe. At that strobe it sets status bit i: bits 7:0 map to status register 1 and bits 15:8 map to status register 2. The strobe ORs new bits into the current contents.
- R3: `rd_data` shows the addressed register in the same cycle as `rd_en`. A read of address 0 (status 1) or address 1 (status 2) clears that register at the clock edge, and a second read before the next strobe returns 0.
- R4: An event pulse in the same cycle as a read-clear of its register, with no strobe, is kept and appears in status after the next strobe.
- R5: The pin is active when enabled and any status bit is set whose mask bit is 0. Status bits whose mask bit is 1 do not activate it.
- R6: After a read-clear removes the last unmasked status bit, the pin is inactive from the next cycle.
- R7: While configuration bit 3 (line clear) is 1, the pin is inactive, `scan_halt` is 1, status contents are kept and `scan_done` strobes are ignored. Events are still collected. Clearing the bit lets the next strobe transfer them.
- R8: Configuration bit 0 enables the pin. While it is 0 the pin stays inactive.
- R9: Configuration bit 1 selects polarity: 0 gives an active-low pin and 1 gives an active-high pin.
- R10: `int_in_n` low activates the pin when it is enabled and line clear is 0, even with no status bits set.
- R11: Writes go to address 2 (mask 1), address 3 (mask 2) and address 4 (configuration), and read back unchanged without side effects. Writes to addresses 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | 16 | Per-bit event pulses from the scan loop |
| scan_done | input | 1 | End-of-pass strobe from the scan loop |
| scan_halt | output | 1 | Holds the scan loop stopped while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (clears status on read) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, valid in the read cycle |
| int_in_n | input | 1 | Chained active-low interrupt from other devices |
| irq_pin | output | 1 | Interrupt output, polarity set by configuration |

## Verification
A hidden accumulator that drops or keeps the wrong bits can only be seen one strobe later, as a wrong status value on the next read. The bench therefore pairs every event stimulus with a strobe and a read. A read-clear that fails shows up on the next cycle, as a nonzero second read or a pin that stays active. Halt faults show up as a status value that changed during the halted interval, which the read after line clear exposes.

// File: rtl/irq_stat_pkg.sv
// Package: shared widths, register addresses and configuration bit positions
// for the interrupt status and mask controller.
package irq_stat_pkg;
    localparam int REG_W   = 8;
    localparam int N_BANKS = 2;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT1 = 3'd0,
        ADR_STAT2 = 3'd1,
        ADR_MASK1 = 3'd2,
        ADR_MASK2 = 3'd3,
        ADR_CFG   = 3'd4
    } reg_addr_e;

    localparam int CFG_EN   = 0;   // pin enable
    localparam int CFG_POL  = 1;   // 1 = active-high pin
    localparam int CFG_LCLR = 3;   // line clear / scan halt
endpackage

// File: rtl/irq_event_bank.sv
// Module: one status register with its hidden event accumulator.
// Events collect in the shadow register; a transfer ORs shadow plus same-cycle
// events into the visible status and empties the shadow. A read-clear zeroes
// the status. Assumes evt carries one-cycle pulses.
module irq_event_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         xfer,
    input  logic         rd_clr,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] shadow_q
);
    logic [W-1:0] shadow_all;

    // Combine held shadow bits with events arriving this cycle.
    always_comb shadow_all = shadow_q | evt;

    // Shadow accumulation: emptied on transfer, otherwise keeps collecting.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (xfer) shadow_q <= '0;
        else           shadow_q <= shadow_all;
    end

    // Visible status: read-clear then OR in transferred bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_clr ? '0 : stat_q) | (xfer ? shadow_all : '0);
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: mask and configuration registers written through the register port.
// Assumes one write per cycle; writes to status addresses are dropped.
module irq_cfg_regs
    import irq_stat_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NB = N_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NB*W-1:0]   mask_q,
    output logic [W-1:0]      cfg_q
);
    // One mask register per bank, addressed after the status registers.
    for (genvar b = 0; b < NB; b++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q[b*W +: W] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(int'(ADR_MASK1) + b))
                mask_q[b*W +: W] <= wr_data;
        end
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (wr_en && wr_addr == ADR_CFG) cfg_q <= wr_data;
    end
endmodule

// File: rtl/irq_line_drive.sv
// Module: combines unmasked status and the chained input into the pin level.
// Assumes mask bit 0 = enabled; the line clear overrides all sources.
module irq_line_drive #(
    parameter int W  = 8,
    parameter int NB = 2
) (
    input  logic [NB*W-1:0] stat,
    input  logic [NB*W-1:0] mask,
    input  logic            en,
    input  logic            pol_high,
    input  logic            line_clr,
    input  logic            ext_n,
    output logic            irq_pin
);
    logic [NB-1:0] bank_hit;
    logic          active;

    // Per-bank reduction of unmasked status bits.
    for (genvar b = 0; b < NB; b++) begin : g_hit
        always_comb bank_hit[b] = |(stat[b*W +: W] & ~mask[b*W +: W]);
    end

    // Final gating and polarity.
    always_comb begin
        active  = en && !line_clr && ((|bank_hit) || !ext_n);
        irq_pin = pol_high ? active : !active;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the interrupt status and mask controller. Instantiates one
// event bank per status register, the mask/config registers and the pin driver,
// and multiplexes the read port. Assumes rd_data is sampled in the read cycle.
module irq_status_ctrl
    import irq_stat_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_BANKS*REG_W-1:0] evt,
    input  logic                    scan_done,
    output logic                    scan_halt,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_data,
    input  logic                    int_in_n,
    output logic                    irq_pin
);
    localparam int TOT_W = N_BANKS * REG_W;

    logic [TOT_W-1:0] stat_flat;
    logic [TOT_W-1:0] shadow_flat;
    logic [TOT_W-1:0] mask_flat;
    logic [REG_W-1:0] cfg_q;
    logic             xfer;

    // Halt follows the line-clear bit; strobes during a halt do not transfer.
    always_comb begin
        scan_halt = cfg_q[CFG_LCLR];
        xfer      = scan_done && !scan_halt;
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic rd_clr;
        // Read-clear for the status register this bank owns.
        always_comb rd_clr = rd_en && (rd_addr == ADDR_W'(b));
        irq_event_bank #(.W(REG_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt[b*REG_W +: REG_W]),
            .xfer     (xfer),
            .rd_clr   (rd_clr),
            .stat_q   (stat_flat[b*REG_W +: REG_W]),
            .shadow_q (shadow_flat[b*REG_W +: REG_W])
        );
    end

    irq_cfg_regs #(.W(REG_W), .NB(N_BANKS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask_q  (mask_flat),
        .cfg_q   (cfg_q)
    );

    irq_line_drive #(.W(REG_W), .NB(N_BANKS)) u_drive (
        .stat     (stat_flat),
        .mask     (mask_flat),
        .en       (cfg_q[CFG_EN]),
        .pol_high (cfg_q[CFG_POL]),
        .line_clr (cfg_q[CFG_LCLR]),
        .ext_n    (int_in_n),
        .irq_pin  (irq_pin)
    );

    // Read multiplexer: status, masks, configuration.
    always_comb begin
        case (rd_addr)
            ADR_STAT1: rd_data = stat_flat[0 +: REG_W];
            ADR_STAT2: rd_data = stat_flat[REG_W +: REG_W];
            ADR_MASK1: rd_data = mask_flat[0 +: REG_W];
            ADR_MASK2: rd_data = mask_flat[REG_W +: REG_W];
            ADR_CFG:   rd_data = cfg_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
// Module: assertion checker bound to irq_status_ctrl.
module irq_status_ctrl_chk #(
    parameter int W  = 8,
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB*W-1:0] evt,
    input logic          scan_done,
    input logic          scan_halt,
    input logic          rd_en,
    input logic [2:0]    rd_addr,
    input logic          irq_pin,
    input logic [W-1:0]  cfg,
    input logic [NB*W-1:0] stat,
    input logic [NB*W-1:0] shadow
);
    for (genvar b = 0; b < NB; b++) begin : g_b
        AST_RDCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == 3'(b) && !(scan_done && !scan_halt))
            |=> stat[b*W +: W] == '0);  // R3
        AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_en && !(scan_done && !scan_halt))
            |=> $stable(stat[b*W +: W]));  // R2
    end

    for (genvar i = 0; i < NB*W; i++) begin : g_e
        AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !(scan_done && !scan_halt)) |=> shadow[i]);  // R4
    end

    AST_LCLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[3] |-> irq_pin == !cfg[1]);  // R7
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_halt && !rd_en) |=> $stable(stat));  // R7
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[0] |-> irq_pin == !cfg[1]);  // R8
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.W(irq_stat_pkg::REG_W), .NB(irq_stat_pkg::N_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .scan_done (scan_done),
    .scan_halt (scan_halt),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .irq_pin   (irq_pin),
    .cfg       (cfg_q),
    .stat      (stat_flat),
    .shadow    (shadow_flat)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        scan_done = 1'b0;
    logic        scan_halt;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        int_in_n = 1'b1;
    logic        irq_pin;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .evt(evt), .scan_done(scan_done),
        .scan_halt(scan_halt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_in_n(int_in_n), .irq_pin(irq_pin)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus; returns rd_data seen before the edge.
    task automatic cyc(input logic [15:0] e, input logic sd, input logic re,
                       input logic [2:0] ra, output logic [7:0] d);
        @(negedge clk);
        evt = e; scan_done = sd; rd_en = re; rd_addr = ra;
        #1 d = rd_data;
        @(posedge clk); #1;
        evt = '0; scan_done = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cyc('0, 1'b0, 1'b1, a, d);
    endtask

    task automatic strobe();
        logic [7:0] d;
        cyc('0, 1'b1, 1'b0, 3'd0, d);
    endtask

    task automatic do_reset();
        logic [7:0] d;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(3'd0, d); check("R1 stat1", d, 0);
        rd(3'd1, d); check("R1 stat2", d, 0);
        rd(3'd2, d); check("R1 mask1", d, 0);
        rd(3'd3, d); check("R1 mask2", d, 0);
        rd(3'd4, d); check("R1 cfg", d, 0);
        check("R1 irq_pin", irq_pin, 1);
        check("R1 scan_halt", scan_halt, 0);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        cyc(16'h0201, 1'b0, 1'b0, 3'd0, d);
        rd(3'd0, d); check("R2 no early stat1", d, 0);
        cyc(16'h8010, 1'b0, 1'b0, 3'd0, d);
        strobe();
        cyc(16'h0004, 1'b1, 1'b0, 3'd0, d);   // OR-in on second strobe
        rd(3'd0, d); check("R2 stat1 after strobes", d, 8'h15);
        rd(3'd1, d); check("R2 stat2 after strobe", d, 8'h82);
        rd(3'd0, d); check("R3 second read stat1", d, 0);
        rd(3'd1, d); check("R3 second read stat2", d, 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        cyc(16'h0040, 1'b1, 1'b0, 3'd0, d);
        cyc(16'h0008, 1'b0, 1'b1, 3'd0, d);
        check("R3 read data", d, 8'h40);
        rd(3'd0, d); check("R4 cleared before strobe", d, 0);
        strobe();
        rd(3'd0, d); check("R4 event kept", d, 8'h08);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h20);                          // mask status2 bit5
        cyc(16'h2000, 1'b1, 1'b0, 3'd0, d);
        check("R5 masked bit quiet", irq_pin, 1);
        cyc(16'h0100, 1'b1, 1'b0, 3'd0, d);
        check("R5 unmasked bit active", irq_pin, 0);
        rd(3'd1, d); check("R6 read data", d, 8'h21);
        check("R6 pin released after read", irq_pin, 1);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_lineclr();
        logic [7:0] d;
        cyc(16'h0004, 1'b1, 1'b0, 3'd0, d);
        check("R7 pin active before clear", irq_pin, 0);
        wr(3'd4, 8'h09);
        check("R7 pin inactive", irq_pin, 1);
        check("R7 halt", scan_halt, 1);
        cyc(16'h0002, 1'b1, 1'b0, 3'd0, d);     // strobe ignored
        rd(3'd0, d); check("R7 status kept", d, 8'h04);
        wr(3'd4, 8'h01);
        check("R7 halt released", scan_halt, 0);
        check("R7 pin idle after release", irq_pin, 1);
        strobe();
        check("R7 pin after resume", irq_pin, 0);
        rd(3'd0, d); check("R7 deferred event", d, 8'h02);
    endtask

    task automatic t_enable_pol();
        logic [7:0] d;
        cyc(16'h0001, 1'b1, 1'b0, 3'd0, d);
        wr(3'd4, 8'h00);
        check("R8 disabled quiet", irq_pin, 1);
        wr(3'd4, 8'h03);
        check("R9 active-high", irq_pin, 1);
        wr(3'd4, 8'h02);
        check("R9 active-high disabled", irq_pin, 0);
        rd(3'd0, d);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_chain();
        wr(3'd4, 8'h01);
        @(negedge clk) int_in_n = 1'b0; #1;
        check("R10 chained low", irq_pin, 0);
        wr(3'd4, 8'h09);
        check("R10 line clear overrides", irq_pin, 1);
        wr(3'd4, 8'h03);
        check("R10 chained active-high", irq_pin, 1);
        @(negedge clk) int_in_n = 1'b1; #1;
        check("R10 released", irq_pin, 0);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(3'd2, 8'hA5);
        wr(3'd3, 8'h5A);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        rd(3'd0, d); check("R11 stat1 not writable", d, 0);
        rd(3'd1, d); check("R11 stat2 not writable", d, 0);
        rd(3'd2, d); check("R11 mask1", d, 8'hA5);
        rd(3'd2, d); check("R11 mask1 no side effect", d, 8'hA5);
        rd(3'd3, d); check("R11 mask2", d, 8'h5A);
        wr(3'd4, 8'h42);
        rd(3'd4, d); check("R11 cfg", d, 8'h42);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_latch();
        t_same_cycle();
        t_mask();
        t_lineclr();
        t_enable_pol();
        t_chain();
        t_regs();
        do_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule